// File: doc/BRIEF.md
# System Clock Source Switch with Failure Fallback

This block chooses which oscillator drives the system clock and derives three bus clocks from it. It works as a clock-enable design: each source oscillator reaches the block as a one-cycle pulse on a fast sampling clock, already synchronized. The system clock and the bus clocks leave the block as one-cycle enable pulses in the same domain. After reset the internal oscillator drives the system clock. Software can then move it to the external oscillator or to the PLL output.

Every change of source is break-before-make. The old source stops first, and the new one is forwarded only after one full period of its own has passed, so no shortened period appears at the output. While the external oscillator is in use, or is the pending target, a watchdog counts internal-oscillator pulses. If eight of them arrive with no external pulse between them, the block declares a failure. It then falls back to the internal oscillator by itself, raises a sticky flag, and drives an interrupt when that is enabled.

Three power-of-two prescalers derive the main bus, fast peripheral bus and slow peripheral bus clocks. Each peripheral divider has a floor, so the fast peripheral clock never exceeds half the main bus clock and the slow one never exceeds a quarter of it. A new prescaler setting takes effect only when the current divided period ends.

Top module: `sysclk_switch`

## Requirements
- R1: After reset `active_src` is 0 (internal), `fail_flag` and `irq` are 0, and `sys_tick` follows internal-oscillator pulses with one cycle of latency.
- R2: A `sel_wr` strobe with `sel_src` = 0 (internal), 1 (external) or 2 (PLL) moves the system clock to that source, and `active_src` reports the code. Code 3 is reserved and ignored.
- R3: After a switch is accepted, `sys_tick` stays low until the new source has produced one pulse. The first forwarded pulse is the new source's second pulse after the request. No interval between `sys_tick` pulses is shorter than the shorter of the two source periods.
- R4: The monitor is armed only while the external source is active or is the pending target. Eight internal pulses with no external pulse between them set `fail_flag`. Fewer pulses do not set it, and nothing is flagged while the monitor is unarmed.
- R5: On a failure the system clock returns to the internal source (`active_src` = 0) with no software action.
- R6: `irq` is high exactly while `fail_flag` is set and `irq_en` is high.
- R7: `fail_flag` stays set until a `fail_clr` strobe. While it is set, a request for the external source is refused and the active source is kept.
- R8: A prescaler code c from 0 to 4 divides by 2^c. Codes 5 to 7 divide by 16. `hclk_tick` divides `sys_tick`, and both peripheral ticks divide `hclk_tick`.
- R9: The fast peripheral divider never divides by less than 2 and the slow one never by less than 4, whatever their codes.
- R10: A prescaler change takes effect only at the end of the divided period in progress: the period running when the code changes keeps the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| int_pulse | input | 1 | One pulse per internal-oscillator period |
| ext_pulse | input | 1 | One pulse per external-oscillator period |
| pll_pulse | input | 1 | One pulse per PLL-output period |
| sel_wr | input | 1 | Source-select strobe |
| sel_src | input | 2 | Requested source: 0 internal, 1 external, 2 PLL, 3 reserved |
| fail_clr | input | 1 | Clears the failure flag |
| irq_en | input | 1 | Interrupt enable |
| hpre | input | 3 | Main bus prescaler code |
| pfast_pre | input | 3 | Fast peripheral prescaler code |
| pslow_pre | input | 3 | Slow peripheral prescaler code |
| sys_tick | output | 1 | System clock enable |
| hclk_tick | output | 1 | Main bus clock enable |
| pfast_tick | output | 1 | Fast peripheral clock enable |
| pslow_tick | output | 1 | Slow peripheral clock enable |
| active_src | output | 2 | Source now driving the system clock |
| fail_flag | output | 1 | Sticky external-clock failure flag |
| irq | output | 1 | Failure interrupt |

## Verification
A wrong switch state shows up within one source period. `sys_tick` either arrives at the old or new source's rate when it should not, or produces an interval shorter than either source period around a switch. A wrong monitor count shows up as `fail_flag` rising before eight internal periods, or never rising, and `active_src` stays wrong. A wrong prescaler register shows up as a divided tick interval that differs from 2^c times its parent period, or as a new ratio applied one period early. The bench measures these intervals cycle by cycle.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_PLL = 2'd2,
    SRC_RSV = 2'd3
  } src_e;

  typedef enum logic {
    SW_RUN = 1'b0,
    SW_GAP = 1'b1
  } sw_state_e;
endpackage

// File: rtl/ckm_fail_mon.sv
module ckm_fail_mon #(
  parameter int FAIL_LIM = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic int_p,
  input  logic ext_p,
  input  logic armed,
  input  logic clr,
  input  logic irq_en,
  output logic fail_evt,
  output logic fail_q,
  output logic irq_q
);
  localparam int CW = $clog2(FAIL_LIM + 1);

  logic [CW-1:0] cnt;
  logic          fail_d;

  // a failure is declared on the internal pulse that completes the window
  assign fail_evt = armed && int_p && !ext_p && !fail_q &&
                    (cnt == CW'(FAIL_LIM - 1));
  assign fail_d   = fail_evt || (fail_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (!armed || ext_p) cnt <= '0;
      else if (int_p)      cnt <= cnt + 1'b1;
      fail_q <= fail_d;
      irq_q  <= fail_d && irq_en;
    end
  end

  assert_fail_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !clr) |=> fail_q);
  assert_no_early_fail_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && ext_p) |=> !fail_evt);
  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> fail_q);
endmodule

// File: rtl/ckm_src_switch.sv
module ckm_src_switch
  import ckm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] src_p,
  input  logic       sel_wr,
  input  logic [1:0] sel_src,
  input  logic       fail_q,
  input  logic       fail_evt,
  output logic       sys_tick,
  output logic [1:0] active,
  output logic       armed
);
  sw_state_e  state;
  src_e       active_q, target_q, req;
  logic [3:0] p4;
  logic       accept, ext_in_use;

  assign p4         = {1'b0, src_p};
  assign req        = src_e'(sel_src);
  assign ext_in_use = (active_q == SRC_EXT) || (target_q == SRC_EXT);
  assign armed      = ext_in_use;
  assign accept     = sel_wr && (req != SRC_RSV) && (req != target_q) &&
                      !((req == SRC_EXT) && fail_q);
  assign active     = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SW_RUN;
      active_q <= SRC_INT;
      target_q <= SRC_INT;
      sys_tick <= 1'b0;
    end else begin
      sys_tick <= (state == SW_RUN) && p4[active_q];
      if (fail_evt && ext_in_use) begin
        state    <= SW_GAP;
        target_q <= SRC_INT;
      end else if (accept) begin
        state    <= SW_GAP;
        target_q <= req;
      end else if ((state == SW_GAP) && p4[target_q]) begin
        state    <= SW_RUN;
        active_q <= target_q;
      end
    end
  end

  assert_switch_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (active_q != $past(active_q)) |-> !sys_tick);
  assert_refuse_ext_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && req == SRC_EXT && fail_q && target_q != SRC_EXT) |=> target_q != SRC_EXT);
  assert_fallback_R5: assert property (@(posedge clk) disable iff (rst)
    (fail_evt && active_q == SRC_EXT) |=> (target_q == SRC_INT && state == SW_GAP));
  assert_no_rsv_R2: assert property (@(posedge clk) disable iff (rst)
    active_q != SRC_RSV);
endmodule

// File: rtl/ckm_tick_div.sv
module ckm_tick_div #(
  parameter int CODEW    = 3,
  parameter int MIN_CODE = 0,
  parameter int MAX_CODE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic [CODEW-1:0] code,
  output logic             tick_out
);
  localparam int CNTW = MAX_CODE;

  logic [CODEW-1:0] cur, eff;
  logic [CNTW-1:0]  cnt;
  logic [CNTW:0]    lim;
  logic             wrap;

  always_comb begin
    if (int'(code) < MIN_CODE)      eff = CODEW'(MIN_CODE);
    else if (int'(code) > MAX_CODE) eff = CODEW'(MAX_CODE);
    else                            eff = code;
  end

  assign lim  = ({{CNTW{1'b0}}, 1'b1} << cur) - 1'b1;
  assign wrap = tick_in && ({1'b0, cnt} == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= CODEW'(MIN_CODE);
      cnt      <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= wrap;
      if (wrap) begin
        cnt <= '0;
        cur <= eff;
      end else if (tick_in) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_div_follows_input_R8: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> $past(tick_in));
  assert_ratio_floor_R9: assert property (@(posedge clk) disable iff (rst)
    (int'(cur) >= MIN_CODE) && (int'(cur) <= MAX_CODE));
  assert_boundary_load_R10: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(cur));
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch #(
  parameter int FAIL_LIM  = 8,
  parameter int CODEW     = 3,
  parameter int MAX_CODE  = 4,
  parameter int FAST_MIN  = 1,
  parameter int SLOW_MIN  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_pulse,
  input  logic             ext_pulse,
  input  logic             pll_pulse,
  input  logic             sel_wr,
  input  logic [1:0]       sel_src,
  input  logic             fail_clr,
  input  logic             irq_en,
  input  logic [CODEW-1:0] hpre,
  input  logic [CODEW-1:0] pfast_pre,
  input  logic [CODEW-1:0] pslow_pre,
  output logic             sys_tick,
  output logic             hclk_tick,
  output logic             pfast_tick,
  output logic             pslow_tick,
  output logic [1:0]       active_src,
  output logic             fail_flag,
  output logic             irq
);
  logic armed, fail_evt;

  ckm_fail_mon #(.FAIL_LIM(FAIL_LIM)) u_mon (
    .clk(clk), .rst(rst), .int_p(int_pulse), .ext_p(ext_pulse),
    .armed(armed), .clr(fail_clr), .irq_en(irq_en),
    .fail_evt(fail_evt), .fail_q(fail_flag), .irq_q(irq)
  );

  ckm_src_switch u_sw (
    .clk(clk), .rst(rst), .src_p({pll_pulse, ext_pulse, int_pulse}),
    .sel_wr(sel_wr), .sel_src(sel_src), .fail_q(fail_flag),
    .fail_evt(fail_evt), .sys_tick(sys_tick), .active(active_src),
    .armed(armed)
  );

  ckm_tick_div #(.CODEW(CODEW), .MIN_CODE(0), .MAX_CODE(MAX_CODE)) u_hdiv (
    .clk(clk), .rst(rst), .tick_in(sys_tick), .code(hpre), .tick_out(hclk_tick)
  );

  ckm_tick_div #(.CODEW(CODEW), .MIN_CODE(FAST_MIN), .MAX_CODE(MAX_CODE)) u_fdiv (
    .clk(clk), .rst(rst), .tick_in(hclk_tick), .code(pfast_pre), .tick_out(pfast_tick)
  );

  ckm_tick_div #(.CODEW(CODEW), .MIN_CODE(SLOW_MIN), .MAX_CODE(MAX_CODE)) u_sdiv (
    .clk(clk), .rst(rst), .tick_in(hclk_tick), .code(pslow_pre), .tick_out(pslow_tick)
  );

  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (fail_flag && irq_en && !fail_clr) |=> irq);
endmodule

// File: tb/sysclk_switch_tb.sv
module sysclk_switch_tb;
  logic clk = 0, rst = 1;
  logic int_pulse = 0, ext_pulse = 0, pll_pulse = 0;
  logic sel_wr = 0, fail_clr = 0, irq_en = 1;
  logic [1:0] sel_src = 0;
  logic [2:0] hpre = 0, pfast_pre = 0, pslow_pre = 0;
  logic sys_tick, hclk_tick, pfast_tick, pslow_tick, fail_flag, irq;
  logic [1:0] active_src;
  logic ext_on = 1;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  sysclk_switch u_dut (
    .clk(clk), .rst(rst), .int_pulse(int_pulse), .ext_pulse(ext_pulse),
    .pll_pulse(pll_pulse), .sel_wr(sel_wr), .sel_src(sel_src),
    .fail_clr(fail_clr), .irq_en(irq_en), .hpre(hpre), .pfast_pre(pfast_pre),
    .pslow_pre(pslow_pre), .sys_tick(sys_tick), .hclk_tick(hclk_tick),
    .pfast_tick(pfast_tick), .pslow_tick(pslow_tick), .active_src(active_src),
    .fail_flag(fail_flag), .irq(irq)
  );

  // source oscillators: internal period 4, external 3, PLL 2
  initial begin
    int c = 0;
    forever @(negedge clk) begin c = (c + 1) % 4; int_pulse = (c == 0); end
  end
  initial begin
    int c = 0;
    forever @(negedge clk) begin c = (c + 1) % 3; ext_pulse = ext_on && (c == 0); end
  end
  initial begin
    int c = 0;
    forever @(negedge clk) begin c = (c + 1) % 2; pll_pulse = (c == 0); end
  end

  function automatic logic sig(input int k);
    case (k)
      0: return sys_tick;
      1: return hclk_tick;
      2: return pfast_tick;
      default: return pslow_tick;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int k);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (sig(k)) return;
    end
  endtask

  task automatic measure(input int k, output int per);
    wait_tick(k);
    per = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      per++;
      if (sig(k)) return;
    end
  endtask

  task automatic select(input logic [1:0] v);
    @(negedge clk); sel_src = v; sel_wr = 1;
    @(negedge clk); sel_wr = 0;
  endtask

  task automatic t_reset();
    int p;
    check(active_src == 0, "R1 active", active_src, 0);
    check(fail_flag == 0 && irq == 0, "R1 flags", {fail_flag, irq}, 0);
    measure(0, p);
    check(p == 4, "R1 sys period", p, 4);
  endtask

  task automatic t_prescale();
    int p;
    hpre = 1; pfast_pre = 0; pslow_pre = 0;
    repeat (200) @(negedge clk);
    measure(1, p); check(p == 8,  "R8 hclk /2", p, 8);
    measure(2, p); check(p == 16, "R9 fast floor /2", p, 16);
    measure(3, p); check(p == 32, "R9 slow floor /4", p, 32);
    hpre = 0; pfast_pre = 3; pslow_pre = 7;
    repeat (300) @(negedge clk);
    measure(1, p); check(p == 4,  "R8 hclk /1", p, 4);
    measure(2, p); check(p == 32, "R8 fast /8", p, 32);
    measure(3, p); check(p == 64, "R8 code 7 as /16", p, 64);
  endtask

  task automatic t_boundary();
    int p;
    hpre = 1;
    repeat (100) @(negedge clk);
    wait_tick(1);
    @(negedge clk);
    hpre = 3;
    p = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      p++;
      if (hclk_tick) break;
    end
    check(p == 8, "R10 old ratio kept", p, 8);
    p = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      p++;
      if (hclk_tick) break;
    end
    check(p == 32, "R10 new ratio", p, 32);
    hpre = 0;
    repeat (100) @(negedge clk);
  endtask

  task automatic t_select();
    int p;
    select(3);
    repeat (20) @(negedge clk);
    check(active_src == 0, "R2 reserved ignored", active_src, 0);
    select(1);
    repeat (20) @(negedge clk);
    check(active_src == 1, "R2 ext active", active_src, 1);
    measure(0, p); check(p == 3, "R2 ext period", p, 3);
    select(2);
    repeat (20) @(negedge clk);
    check(active_src == 2, "R2 pll active", active_src, 2);
    measure(0, p); check(p == 2, "R2 pll period", p, 2);
  endtask

  task automatic t_gap();
    int last = -1, mn = 1000, mx = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (i == 10) begin sel_src = 0; sel_wr = 1; end
      if (i == 11) sel_wr = 0;
      if (sys_tick) begin
        if (last >= 0) begin
          if (i - last < mn) mn = i - last;
          if (i - last > mx) mx = i - last;
        end
        last = i;
      end
    end
    check(mn >= 2, "R3 no runt interval", mn, 2);
    check(mx >= 5, "R3 break before make gap", mx, 5);
    check(active_src == 0, "R3 int after switch", active_src, 0);
  endtask

  task automatic t_fail();
    int p;
    select(1);
    repeat (20) @(negedge clk);
    ext_on = 0;
    repeat (20) @(negedge clk);
    check(fail_flag == 0, "R4 not before 8 pulses", fail_flag, 0);
    check(active_src == 1, "R4 still ext", active_src, 1);
    repeat (40) @(negedge clk);
    check(fail_flag == 1, "R4 failure flagged", fail_flag, 1);
    check(active_src == 0, "R5 fallback to int", active_src, 0);
    check(irq == 1, "R6 irq raised", irq, 1);
    measure(0, p); check(p == 4, "R5 int period", p, 4);
    ext_on = 1;
    select(1);
    repeat (20) @(negedge clk);
    check(active_src == 0, "R7 ext refused", active_src, 0);
    check(fail_flag == 1, "R7 flag sticky", fail_flag, 1);
    @(negedge clk); fail_clr = 1;
    @(negedge clk); fail_clr = 0;
    repeat (2) @(negedge clk);
    check(fail_flag == 0 && irq == 0, "R7 cleared", {fail_flag, irq}, 0);
    select(1);
    repeat (20) @(negedge clk);
    check(active_src == 1, "R7 ext accepted after clear", active_src, 1);
  endtask

  task automatic t_irq_off();
    irq_en = 0;
    ext_on = 0;
    repeat (70) @(negedge clk);
    check(fail_flag == 1 && active_src == 0, "R5 fallback again", {fail_flag, active_src}, 4);
    check(irq == 0, "R6 irq masked", irq, 0);
    @(negedge clk); fail_clr = 1;
    @(negedge clk); fail_clr = 0;
    repeat (80) @(negedge clk);
    check(fail_flag == 0, "R4 unarmed on int", fail_flag, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_prescale();
    t_boundary();
    t_select();
    t_gap();
    t_fail();
    t_irq_off();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule